// File: doc/BRIEF.md
# Two-Rail Overcurrent Hiccup Retry Sequencer

This block supervises overcurrent faults for a supply with two rails: a multiphase core rail and a single-phase auxiliary rail. Each rail's overcurrent comparator result is synchronized and fed to its own small state machine. That machine walks through soft-start, run and off states. On a trip, the machine forces the rail's gate drives low for a programmable off period. It then requests a new soft-start. A raised-threshold select is asserted while soft-start is in progress.

Each rail counts its trips since its last completed soft-start. A completed soft-start clears that count, so a fault that only trips at the nominal threshold cycles forever in hiccup. A rail whose retries are used up latches the whole device off. Only a reset (the power-on reset) clears that latch. On the core rail, each phase also has a cycle-by-cycle current-limit override, which turns the upper switch off and the lower switch on for that phase alone.

A core trip taken while power saving is requested restarts the supply with power saving released. It stays released until the host withdraws its request and asserts it again.

Top module: `hiccup_retry_ctrl`

## Requirements
- R1: While `rst` is high, every gate output is 0, `latched_off` is 0 and `psi_n` is 1. In the second cycle after `rst` falls, both rails are in soft-start: `core_ss_req`, `aux_ss_req`, `core_hi_thr` and `aux_hi_thr` are all 1. During soft-start the gates follow PWM: upper = pwm and lower = not pwm.
- R2: A rail's overcurrent input that stays high for at least 3 cycles forces that rail's gate outputs to 0 by the fourth cycle. The gates stay at 0, with `*_ss_req` at 0, for `OFF_CYCLES` cycles. The rail then re-enters soft-start with `*_ss_req` = 1.
- R3: `*_hi_thr` is 1 whenever that rail's `*_ss_req` is 1. Both drop to 0 one cycle after `*_ss_done` is seen high during soft-start.
- R4: A completed soft-start clears the rail's retry count. Any number of trip / off / completed soft-start cycles therefore never sets `latched_off`.
- R5: If a rail trips again during soft-start after `MAX_RETRY` (7) retries without a completed soft-start, `latched_off` goes to 1. From then on, all gate outputs of both rails are 0 and both `*_ss_req` are 0. This lasts until `rst`, whatever the other inputs do.
- R6: An auxiliary-rail trip forces only `aux_ug`/`aux_lg` low. The core gates keep following PWM.
- R7: `psi_n` is 1 whenever `psi_req_n` was 1 in the previous cycle. If the core trips while `psi_req_n` is 0, `psi_n` stays 1 until `psi_req_n` has returned to 1. When `psi_req_n` is 0 again after that, `psi_n` goes to 0.
- R8: When bit i of `core_lim_in` is 1 in a cycle, `core_ug[i]` is 0 and `core_lg[i]` is 1 in the next cycle. The other channels are unaffected. `core_ug` and `core_lg` are never both 1 on the same channel.
- R9: When `core_lim_in[i]` returns to 0, channel i follows `core_pwm[i]` again in the next cycle.
- R10: During a rail's off period, its PWM inputs are ignored and both of its gate outputs stay 0.
- R11: Retry exhaustion on the auxiliary rail also latches off both rails, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| core_oc_in | input | 1 | Core overcurrent comparator, asynchronous |
| aux_oc_in | input | 1 | Auxiliary overcurrent comparator, asynchronous |
| core_lim_in | input | NUM_PH | Per-phase current-limit flags, core |
| core_ss_done | input | 1 | Core soft-start finished |
| aux_ss_done | input | 1 | Auxiliary soft-start finished |
| core_pwm | input | NUM_PH | Core per-phase PWM |
| aux_pwm | input | 1 | Auxiliary PWM |
| psi_req_n | input | 1 | Host power-saving request, active low |
| core_ug | output | NUM_PH | Core upper gate drives |
| core_lg | output | NUM_PH | Core lower gate drives |
| aux_ug | output | 1 | Auxiliary upper gate drive |
| aux_lg | output | 1 | Auxiliary lower gate drive |
| core_ss_req | output | 1 | Core soft-start request |
| aux_ss_req | output | 1 | Auxiliary soft-start request |
| core_hi_thr | output | 1 | Core raised-threshold select |
| aux_hi_thr | output | 1 | Auxiliary raised-threshold select |
| psi_n | output | 1 | Power-saving select to the regulator, active low |
| latched_off | output | 1 | Device latched off after retry exhaustion |

## Verification
The per-phase override is driven from a table of PWM and limit patterns. These include all-clear, alternating limits, limits on phases whose PWM is low, and a full release. Together they separate "upper switch off", "lower switch on" and "phase untouched".

Overcurrent is applied in three forms:
- Short pulses on the auxiliary rail. These show that the core rail is isolated from the auxiliary rail.
- Pulses on the core rail that end before soft-start completes. Ten of these in a row show that the counter clears and that hiccup never latches.
- A level held high on one rail. This must reach latch-off and stay latched after it is removed.

Running the held level on each rail in turn shows that either rail's exhaustion kills both.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    RS_SOFT = 2'd0,
    RS_RUN  = 2'd1,
    RS_OFF  = 2'd2
  } rail_st_e;
endpackage

// File: rtl/hiccup_sync2.sv
module hiccup_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hiccup_rail_seq.sv
module hiccup_rail_seq
  import hiccup_pkg::*;
#(
  parameter int OFF_CYCLES = 16,
  parameter int MAX_RETRY  = 7
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     kill,
  input  logic     oc,
  input  logic     ss_done,
  output rail_st_e st,
  output logic     trip,
  output logic     exhaust
);
  localparam int CNT_W = $clog2(MAX_RETRY + 1);
  localparam int TW    = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RETRY);
  localparam logic [TW-1:0]    TMR_END = TW'(OFF_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic [TW-1:0]    tmr;

  // A trip counts only where the rail is energized; faults in the off period are ignored.
  assign trip    = !kill && oc && (st == RS_SOFT || st == RS_RUN);
  assign exhaust = !kill && oc && (st == RS_SOFT) && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= RS_SOFT;
      cnt <= '0;
      tmr <= '0;
    end else if (!kill) begin
      unique case (st)
        RS_SOFT: begin
          if (oc) begin
            if (cnt != CNT_MAX) begin
              st  <= RS_OFF;
              cnt <= cnt + 1'b1;
              tmr <= '0;
            end
          end else if (ss_done) begin
            st  <= RS_RUN;
            cnt <= '0;
          end
        end
        RS_RUN: begin
          if (oc) begin
            st  <= RS_OFF;
            cnt <= cnt + 1'b1;
            tmr <= '0;
          end
        end
        RS_OFF: begin
          if (tmr == TMR_END) begin
            st  <= RS_SOFT;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= RS_OFF;
      endcase
    end
  end
endmodule

// File: rtl/hiccup_gate_bank.sv
module hiccup_gate_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         allow,
  input  logic [N-1:0] pwm,
  input  logic [N-1:0] lim,
  output logic [N-1:0] ug,
  output logic [N-1:0] lg
);
  for (genvar i = 0; i < N; i++) begin : g_ph
    always_ff @(posedge clk) begin
      if (rst || !allow) begin
        ug[i] <= 1'b0;
        lg[i] <= 1'b0;
      end else begin
        ug[i] <= pwm[i] & ~lim[i];
        lg[i] <= ~pwm[i] | lim[i];
      end
    end
  end
endmodule

// File: rtl/hiccup_retry_ctrl.sv
module hiccup_retry_ctrl
  import hiccup_pkg::*;
#(
  parameter int NUM_PH     = 4,
  parameter int OFF_CYCLES = 16,
  parameter int MAX_RETRY  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_oc_in,
  input  logic              aux_oc_in,
  input  logic [NUM_PH-1:0] core_lim_in,
  input  logic              core_ss_done,
  input  logic              aux_ss_done,
  input  logic [NUM_PH-1:0] core_pwm,
  input  logic              aux_pwm,
  input  logic              psi_req_n,
  output logic [NUM_PH-1:0] core_ug,
  output logic [NUM_PH-1:0] core_lg,
  output logic              aux_ug,
  output logic              aux_lg,
  output logic              core_ss_req,
  output logic              aux_ss_req,
  output logic              core_hi_thr,
  output logic              aux_hi_thr,
  output logic              psi_n,
  output logic              latched_off
);
  logic [1:0] oc_s;
  rail_st_e   core_st, aux_st;
  logic       core_trip, aux_trip, core_exh, aux_exh;
  logic       latch_q, ps_block;
  logic       core_allow, aux_allow;

  hiccup_sync2 #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({aux_oc_in, core_oc_in}),
    .q   (oc_s)
  );

  hiccup_rail_seq #(.OFF_CYCLES(OFF_CYCLES), .MAX_RETRY(MAX_RETRY)) u_core_seq (
    .clk     (clk),
    .rst     (rst),
    .kill    (latch_q),
    .oc      (oc_s[0]),
    .ss_done (core_ss_done),
    .st      (core_st),
    .trip    (core_trip),
    .exhaust (core_exh)
  );

  hiccup_rail_seq #(.OFF_CYCLES(OFF_CYCLES), .MAX_RETRY(MAX_RETRY)) u_aux_seq (
    .clk     (clk),
    .rst     (rst),
    .kill    (latch_q),
    .oc      (oc_s[1]),
    .ss_done (aux_ss_done),
    .st      (aux_st),
    .trip    (aux_trip),
    .exhaust (aux_exh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= 1'b0;
      ps_block <= 1'b0;
      psi_n    <= 1'b1;
    end else begin
      if (core_exh || aux_exh) latch_q <= 1'b1;
      if (psi_req_n)      ps_block <= 1'b0;
      else if (core_trip) ps_block <= 1'b1;
      psi_n <= psi_req_n | ps_block;
    end
  end

  assign core_allow  = (core_st != RS_OFF) && !latch_q;
  assign aux_allow   = (aux_st  != RS_OFF) && !latch_q;

  hiccup_gate_bank #(.N(NUM_PH)) u_core_gates (
    .clk   (clk),
    .rst   (rst),
    .allow (core_allow),
    .pwm   (core_pwm),
    .lim   (core_lim_in),
    .ug    (core_ug),
    .lg    (core_lg)
  );

  hiccup_gate_bank #(.N(1)) u_aux_gates (
    .clk   (clk),
    .rst   (rst),
    .allow (aux_allow),
    .pwm   (aux_pwm),
    .lim   (1'b0),
    .ug    (aux_ug),
    .lg    (aux_lg)
  );

  assign core_ss_req = (core_st == RS_SOFT) && !latch_q;
  assign aux_ss_req  = (aux_st  == RS_SOFT) && !latch_q;
  assign core_hi_thr = core_ss_req;
  assign aux_hi_thr  = aux_ss_req;
  assign latched_off = latch_q;

  logic unused_aux_trip;
  assign unused_aux_trip = aux_trip;
endmodule

// File: rtl/hiccup_retry_ctrl_chk.sv
module hiccup_retry_ctrl_chk #(
  parameter int NUM_PH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_PH-1:0] core_lim_in,
  input logic              psi_req_n,
  input logic [NUM_PH-1:0] core_ug,
  input logic [NUM_PH-1:0] core_lg,
  input logic              aux_ug,
  input logic              aux_lg,
  input logic              core_ss_req,
  input logic              aux_ss_req,
  input logic              core_hi_thr,
  input logic              aux_hi_thr,
  input logic              psi_n,
  input logic              latched_off
);
  // R5
  latch_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    latched_off |=> latched_off);

  // R5
  latch_gates_chk: assert property (@(posedge clk) disable iff (rst)
    latched_off |=> (core_ug == '0 && core_lg == '0 && !aux_ug && !aux_lg));

  // R5
  latch_noreq_chk: assert property (@(posedge clk) disable iff (rst)
    latched_off |-> (!core_ss_req && !aux_ss_req));

  // R3
  core_thr_chk: assert property (@(posedge clk) disable iff (rst)
    core_ss_req |-> core_hi_thr);

  // R3
  aux_thr_chk: assert property (@(posedge clk) disable iff (rst)
    aux_ss_req |-> aux_hi_thr);

  // R8
  lim_forces_chk: assert property (@(posedge clk) disable iff (rst)
    (core_ug & $past(core_lim_in)) == '0);

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (core_ug & core_lg) == '0 && !(aux_ug && aux_lg));

  // R7
  psi_release_chk: assert property (@(posedge clk) disable iff (rst)
    psi_req_n |=> psi_n);
endmodule

bind hiccup_retry_ctrl hiccup_retry_ctrl_chk #(.NUM_PH(NUM_PH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .core_lim_in (core_lim_in),
  .psi_req_n   (psi_req_n),
  .core_ug     (core_ug),
  .core_lg     (core_lg),
  .aux_ug      (aux_ug),
  .aux_lg      (aux_lg),
  .core_ss_req (core_ss_req),
  .aux_ss_req  (aux_ss_req),
  .core_hi_thr (core_hi_thr),
  .aux_hi_thr  (aux_hi_thr),
  .psi_n       (psi_n),
  .latched_off (latched_off)
);

// File: tb/hiccup_retry_ctrl_test.sv
`timescale 1ns/1ps
module hiccup_retry_ctrl_test;
  localparam int NPH = 4;
  localparam int OFF = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_oc_in = 1'b0, aux_oc_in = 1'b0;
  logic [NPH-1:0] core_lim_in = '0;
  logic core_ss_done = 1'b0, aux_ss_done = 1'b0;
  logic [NPH-1:0] core_pwm = '0;
  logic aux_pwm = 1'b0;
  logic psi_req_n = 1'b1;
  logic [NPH-1:0] core_ug, core_lg;
  logic aux_ug, aux_lg, core_ss_req, aux_ss_req, core_hi_thr, aux_hi_thr, psi_n, latched_off;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hiccup_retry_ctrl #(.NUM_PH(NPH), .OFF_CYCLES(OFF), .MAX_RETRY(7)) uut (
    .clk(clk), .rst(rst), .core_oc_in(core_oc_in), .aux_oc_in(aux_oc_in),
    .core_lim_in(core_lim_in), .core_ss_done(core_ss_done), .aux_ss_done(aux_ss_done),
    .core_pwm(core_pwm), .aux_pwm(aux_pwm), .psi_req_n(psi_req_n),
    .core_ug(core_ug), .core_lg(core_lg), .aux_ug(aux_ug), .aux_lg(aux_lg),
    .core_ss_req(core_ss_req), .aux_ss_req(aux_ss_req), .core_hi_thr(core_hi_thr),
    .aux_hi_thr(aux_hi_thr), .psi_n(psi_n), .latched_off(latched_off)
  );

  // {pwm, lim, expected ug, expected lg} for the four core phases (R8, R9)
  localparam logic [15:0] LIM_TAB [6] = '{
    16'b1111_0000_1111_0000,
    16'b1111_0101_1010_0101,
    16'b0000_1000_0000_1111,
    16'b1010_0010_1000_0111,
    16'b0110_1111_0000_1111,
    16'b1111_0000_1111_0000
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic core_trip_pulse();
    core_oc_in = 1'b1; cyc(3); core_oc_in = 1'b0;
  endtask

  task automatic core_finish_ss();
    core_ss_done = 1'b1; cyc(1); core_ss_done = 1'b0; cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1 ug in reset", {core_ug, aux_ug}, 0);
    chk("R1 latch in reset", latched_off, 0);
    chk("R1 psi in reset", psi_n, 1);
    rst = 1'b0;
    cyc(2);
    chk("R1 ss_req after reset", {core_ss_req, aux_ss_req, core_hi_thr, aux_hi_thr}, 4'b1111);
    core_pwm = 4'b1010; aux_pwm = 1'b1;
    cyc(1);
    chk("R1 gates follow pwm", {core_ug, core_lg, aux_ug, aux_lg}, {4'b1010, 4'b0101, 2'b10});

    // R3 soft-start completion drops threshold
    core_ss_done = 1'b1; aux_ss_done = 1'b1; cyc(1);
    core_ss_done = 1'b0; aux_ss_done = 1'b0; cyc(1);
    chk("R3 thr after done", {core_ss_req, aux_ss_req, core_hi_thr, aux_hi_thr}, 4'b0000);

    // R8 / R9 table walk
    for (int k = 0; k < 6; k++) begin
      core_pwm = LIM_TAB[k][15:12];
      core_lim_in = LIM_TAB[k][11:8];
      cyc(1);
      chk("R8 R9 ug", core_ug, LIM_TAB[k][7:4]);
      chk("R8 R9 lg", core_lg, LIM_TAB[k][3:0]);
    end
    core_lim_in = '0;

    // R6 / R10 / R2 auxiliary trip
    core_pwm = 4'b0011; aux_pwm = 1'b1;
    aux_oc_in = 1'b1; cyc(3); aux_oc_in = 1'b0;
    cyc(1);
    chk("R10 aux gates off", {aux_ug, aux_lg}, 2'b00);
    chk("R6 core unaffected", {core_ug, core_lg}, {4'b0011, 4'b1100});
    aux_pwm = 1'b0; cyc(2);
    chk("R10 aux pwm ignored", {aux_ug, aux_lg}, 2'b00);
    chk("R2 no req during off", aux_ss_req, 0);
    cyc(OFF);
    chk("R2 aux retry request", {aux_ss_req, aux_hi_thr}, 2'b11);
    chk("R1 aux gates back", {aux_ug, aux_lg}, 2'b01);
    aux_ss_done = 1'b1; cyc(1); aux_ss_done = 1'b0; cyc(1);

    // R7 power-saving dropped on core trip
    psi_req_n = 1'b0; cyc(2);
    chk("R7 psi follows request", psi_n, 0);
    core_trip_pulse();
    cyc(2);
    chk("R2 core gates off", {core_ug, core_lg}, 0);
    cyc(OFF + 2);
    chk("R2 core retry request", core_ss_req, 1);
    chk("R7 psi held normal", psi_n, 1);
    core_finish_ss();
    psi_req_n = 1'b1; cyc(2);
    psi_req_n = 1'b0; cyc(2);
    chk("R7 psi re-armed", psi_n, 0);
    psi_req_n = 1'b1;

    // R4 endless hiccup without latch
    for (int k = 0; k < 10; k++) begin
      core_trip_pulse();
      cyc(OFF + 4);
      chk("R4 retry requested", core_ss_req, 1);
      core_finish_ss();
    end
    chk("R4 never latched", latched_off, 0);

    // R5 core exhaustion
    core_pwm = 4'b1111; aux_pwm = 1'b1;
    core_oc_in = 1'b1;
    cyc(40);
    chk("R5 not yet latched", latched_off, 0);
    cyc(260);
    chk("R5 latched", latched_off, 1);
    core_oc_in = 1'b0; core_ss_done = 1'b1; aux_ss_done = 1'b1; cyc(50);
    core_ss_done = 1'b0; aux_ss_done = 1'b0;
    chk("R5 still latched", latched_off, 1);
    chk("R5 all gates off", {core_ug, core_lg, aux_ug, aux_lg}, 0);
    chk("R5 no requests", {core_ss_req, aux_ss_req}, 2'b00);
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(2);
    chk("R5 reset clears latch", {latched_off, core_ss_req}, 2'b01);

    // R11 auxiliary exhaustion kills both
    aux_oc_in = 1'b1;
    cyc(300);
    aux_oc_in = 1'b0; cyc(5);
    chk("R11 latched by aux", latched_off, 1);
    chk("R11 core gates off", {core_ug, core_lg}, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule